// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block holds the registers of one 32-pin general-purpose I/O port. A simple synchronous bus carries an address, write enable, write data, read enable and read data. Through it, software reaches three registers. The direction register selects input or output for each pin. The output latch holds the value driven on output pins. The input register is read-only and reports the synchronized pin levels. Three write-only action addresses set, clear or invert chosen bits of the output latch in a single bus write. No read-modify-write sequence is needed for this.

A port enable input models the port clock gate. A small access state machine has two states, `ST_GATED` and `ST_READY`. It takes transition `EN_SEEN` (`ST_GATED` to `ST_READY`) on the first clock edge where the port enable is high. It takes transition `EN_DROPPED` (`ST_READY` to `ST_GATED`) on the first clock edge where the port enable is low. In `ST_GATED`, writes are ignored, reads return zero and every register keeps its value. Reset places the machine in `ST_GATED`.

Register map by word address: 0 direction, 1 output latch, 2 set, 3 clear, 4 toggle, 5 input. Addresses 6 and 7 are unmapped.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the direction register and output latch are zero, `pad_oe` and `pad_out` are all zero, and the access machine is in `ST_GATED`.
- R2: Address 0 is the direction register and reads back what was written; `pad_oe` equals it bit for bit (1 = output, 0 = input). Address 1 is the output latch and reads back what was written.
- R3: `pad_out` carries an output latch bit only where the direction bit is 1; elsewhere it is 0.
- R4: A write to address 2 forces to 1 every latch bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A write to address 3 forces to 0 every latch bit whose write-data bit is 1 and leaves the others unchanged.
- R6: A write to address 4 inverts every latch bit whose write-data bit is 1 and leaves the others unchanged.
- R7: Address 5 returns the pad levels through a two-flop synchronizer. A level that is stable before two clock edges is seen by a read issued after them. A read issued in the same cycle as a pad change still returns the old level. Writes to address 5 have no effect.
- R8: Addresses 2, 3 and 4 read as zero. Addresses 6 and 7 read as zero, and writes to them change nothing.
- R9: While the machine is in `ST_GATED`, writes are ignored, reads return zero, and the latch and direction keep their values. Access is accepted from the cycle after the port enable is first sampled high.
- R10: Read data is registered. It appears one clock after the cycle with `rd_en` high, and it is zero in any cycle that follows one without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port clock enable; access is gated while low |
| addr | input | 3 | Word address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output value |

## Verification
A corrupted output latch or direction bit shows up on `pad_out` or `pad_oe` on the clock edge that commits the faulty write, and in the data of the next read one cycle later. An access machine stuck in the wrong state shows up at once: either writes are lost and reads return zero, or a gated port still accepts writes. A synchronizer with the wrong depth moves the cycle in which a new pad level first appears on a read by one clock, so the bench compares the old and the new value against exact read cycles.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Word addresses of the port registers
    localparam logic [2:0] A_DIR = 3'd0;
    localparam logic [2:0] A_OUT = 3'd1;
    localparam logic [2:0] A_SET = 3'd2;
    localparam logic [2:0] A_CLR = 3'd3;
    localparam logic [2:0] A_TGL = 3'd4;
    localparam logic [2:0] A_IN  = 3'd5;

    typedef enum logic {
        ST_GATED = 1'b0,
        ST_READY = 1'b1
    } port_state_t;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_LOAD = 3'd1,
        OP_SET  = 3'd2,
        OP_CLR  = 3'd3,
        OP_TGL  = 3'd4
    } latch_op_t;

endpackage

// File: rtl/gpio_access_fsm.sv
module gpio_access_fsm
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    output logic acc_ok
);

    port_state_t state_q;
    port_state_t state_d;

    // next-state logic: EN_SEEN and EN_DROPPED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATED: if (port_en)  state_d = ST_READY;
            ST_READY: if (!port_en) state_d = ST_GATED;
            default:                state_d = ST_GATED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GATED;
        else        state_q <= state_d;
    end

    // output logic
    always_comb begin
        unique case (state_q)
            ST_READY: acc_ok = 1'b1;
            default:  acc_ok = 1'b0;
        endcase
    end

    // R9
    en_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> acc_ok);

    // R9
    en_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !acc_ok);

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign synced = chain[LAST];

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  latch_op_t        op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);

    logic [WIDTH-1:0] out_d;

    always_comb begin
        out_d = out_q;
        unique case (op)
            OP_LOAD: out_d = wdata;
            OP_SET:  out_d = out_q | wdata;
            OP_CLR:  out_d = out_q & ~wdata;
            OP_TGL:  out_d = out_q ^ wdata;
            default: out_d = out_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (dir_we) dir_q <= wdata;
            out_q <= out_d;
        end
    end

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SET) |=> (((out_q & $past(wdata)) == $past(wdata)) &&
                            ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))));

    // R5
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLR) |=> (((out_q & $past(wdata)) == '0) &&
                            ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))));

    // R6
    tgl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TGL) |=> ((out_q ^ $past(out_q)) == $past(wdata)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int ADDR_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PINS-1:0]   wr_data,
    input  logic              rd_en,
    output logic [PINS-1:0]   rd_data,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out
);

    logic            acc_ok;
    logic            wr_ok;
    logic            rd_ok;
    logic            dir_we;
    latch_op_t       op;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] in_q;
    logic [PINS-1:0] rmux;
    logic [2:0]      reg_sel;

    assign reg_sel = 3'(addr);

    gpio_access_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_en (port_en),
        .acc_ok  (acc_ok)
    );

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pad_in),
        .synced (in_q)
    );

    gpio_out_latch #(.WIDTH(PINS)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_we (dir_we),
        .op     (op),
        .wdata  (wr_data),
        .dir_q  (dir_q),
        .out_q  (out_q)
    );

    assign wr_ok = acc_ok & wr_en;
    assign rd_ok = acc_ok & rd_en;

    // write decode
    always_comb begin
        dir_we = 1'b0;
        op     = OP_NONE;
        if (wr_ok) begin
            unique case (reg_sel)
                A_DIR:   dir_we = 1'b1;
                A_OUT:   op = OP_LOAD;
                A_SET:   op = OP_SET;
                A_CLR:   op = OP_CLR;
                A_TGL:   op = OP_TGL;
                default: op = OP_NONE;
            endcase
        end
    end

    // read select
    always_comb begin
        unique case (reg_sel)
            A_DIR:   rmux = dir_q;
            A_OUT:   rmux = out_q;
            A_IN:    rmux = in_q;
            default: rmux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_ok) rd_data <= rmux;
        else            rd_data <= '0;
    end

    assign pad_oe  = dir_q;
    assign pad_out = out_q & dir_q;

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |=> ($stable(dir_q) && $stable(out_q)));

    // R9
    gate_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |=> (rd_data == '0));

    // R8
    alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (reg_sel == A_SET || reg_sel == A_CLR || reg_sel == A_TGL)) |=> (rd_data == '0));

    // R7
    in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == A_IN) |=> ($stable(dir_q) && $stable(out_q)));

endmodule

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;

    logic        clk;
    logic        rst_n;
    logic        port_en;
    logic [2:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [31:0] rd_data;
    logic [31:0] pad_in;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int checks;
    int fails;
    bit done;

    gpio_port_regs uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_en (port_en),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .pad_in  (pad_in),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; port_en = 1'b0; addr = '0; wr_en = 1'b0;
        wr_data = '0; rd_en = 1'b0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 rd_data", rd_data, 32'h0);
    endtask

    task automatic t_gated;
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        chk("R9 gated write dir", pad_oe, 32'h0);
        rd(3'd0, v);
        chk("R9 gated read", v, 32'h0);
        @(negedge clk); port_en = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd0, v);
        chk("R1 dir after reset", v, 32'h0);
        rd(3'd1, v);
        chk("R1 latch after reset", v, 32'h0);
    endtask

    task automatic t_direction;
        logic [31:0] v;
        wr(3'd0, 32'h0000_FFFF);
        rd(3'd0, v);
        chk("R2 dir readback", v, 32'h0000_FFFF);
        chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
        wr(3'd1, 32'hA5A5_A5A5);
        rd(3'd1, v);
        chk("R2 latch readback", v, 32'hA5A5_A5A5);
        chk("R3 pad_out masked", pad_out, 32'h0000_A5A5);
        @(negedge clk);
        chk("R10 idle read zero", rd_data, 32'h0);
    endtask

    task automatic t_setclr;
        logic [31:0] v;
        wr(3'd1, 32'h0000_00F0);
        wr(3'd2, 32'h0000_000F);
        rd(3'd1, v);
        chk("R4 set", v, 32'h0000_00FF);
        wr(3'd2, 32'h0);
        rd(3'd1, v);
        chk("R4 set zero", v, 32'h0000_00FF);
        wr(3'd3, 32'h0000_0033);
        rd(3'd1, v);
        chk("R5 clear", v, 32'h0000_00CC);
        wr(3'd3, 32'h0);
        rd(3'd1, v);
        chk("R5 clear zero", v, 32'h0000_00CC);
    endtask

    task automatic t_toggle;
        logic [31:0] v;
        wr(3'd4, 32'hFFFF_0000);
        rd(3'd1, v);
        chk("R6 toggle", v, 32'hFFFF_00CC);
        chk("R3 pad_out after toggle", pad_out, 32'h0000_00CC);
        wr(3'd4, 32'hFFFF_0000);
        rd(3'd1, v);
        chk("R6 toggle back", v, 32'h0000_00CC);
    endtask

    task automatic t_readzero;
        logic [31:0] v;
        rd(3'd2, v); chk("R8 set reads zero", v, 32'h0);
        rd(3'd3, v); chk("R8 clear reads zero", v, 32'h0);
        rd(3'd4, v); chk("R8 toggle reads zero", v, 32'h0);
        rd(3'd6, v); chk("R8 unmapped reads zero", v, 32'h0);
        wr(3'd7, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd1, v); chk("R8 unmapped write latch", v, 32'h0000_00CC);
        rd(3'd0, v); chk("R8 unmapped write dir", v, 32'h0000_FFFF);
    endtask

    task automatic t_input;
        logic [31:0] v;
        @(negedge clk); pad_in = 32'h1234_5678;
        repeat (2) @(negedge clk);
        rd(3'd5, v);
        chk("R7 input level", v, 32'h1234_5678);
        @(negedge clk);
        pad_in = 32'hCAFE_0001; addr = 3'd5; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R7 sync old value", rd_data, 32'h1234_5678);
        repeat (2) @(negedge clk);
        wr(3'd5, 32'h0);
        rd(3'd5, v);
        chk("R7 input ignores write", v, 32'hCAFE_0001);
        rd(3'd1, v);
        chk("R7 write leaves latch", v, 32'h0000_00CC);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        @(negedge clk); port_en = 1'b0;
        repeat (2) @(negedge clk);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0);
        rd(3'd1, v);
        chk("R9 disabled read zero", v, 32'h0);
        chk("R9 latch kept", pad_out, 32'h0000_00CC);
        chk("R9 dir kept", pad_oe, 32'h0000_FFFF);
        @(negedge clk); port_en = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd1, v);
        chk("R9 latch after re-enable", v, 32'h0000_00CC);
    endtask

    initial begin
        checks = 0; fails = 0; done = 1'b0;
        t_reset();
        t_gated();
        t_direction();
        t_setclr();
        t_toggle();
        t_readzero();
        t_input();
        t_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule